// File: doc/BRIEF.md
# RF Gap Write Decoder

This block receives a write command that a reader sends by briefly interrupting the carrier field. It runs on the recovered field clock. Its input is a synchronised, one-clock gap-detect pulse. It measures the number of field clocks between successive gaps and sorts each interval into a 0 bit, a 1 bit, or a bad interval. Valid bits are shifted into a command register and counted.

When the field has carried no gap for the quiet limit, the block judges the whole command. The command is good only if it has exactly 38 bits, starts with the write opcode and contains no bad interval. A good command is latched and raises a programming request. Any other outcome raises a read-restart request, which tells the reader side to resume at block 1, bit 1. While a command is being received, the block drives write mode and load damping.

Control is a four-state machine:

- **OFF** (disarmed): configuration not yet loaded, or the OTP-disable mode bit is set.
- **IDLE** (armed, waiting for a start gap).
- **WRITE** (receiving bits).
- **REPORT** (one clock, issues the result pulse).

The transitions are:

- **arm**: OFF to IDLE, when the configuration is loaded and OTP-disable is clear.
- **start**: IDLE to WRITE, on a gap.
- **bit**: WRITE to WRITE, on a gap.
- **quiet**: WRITE to REPORT, when the quiet limit is reached with no gap.
- **done**: REPORT to IDLE.
- **disarm**: IDLE or WRITE to OFF, when the arm condition is lost.

Top module: `rf_gap_write_decoder`

## Requirements
- R1: After reset, and until a start gap is accepted, write_mode, damp_en, prog_req, rd_restart, cmd_lock, cmd_data and cmd_addr are all 0.
- R2: While cfg_loaded is 0 or otp_disable is 1, gap pulses are ignored: write_mode stays 0 and neither pulse is issued. Losing the arm condition during a command clears write_mode on the next clock and suppresses the result pulse for that command.
- R3: When armed and idle, a gap pulse sampled on a clock edge is the start gap. From the next clock, write_mode and damp_en are 1, and they stay 1 until the command ends.
- R4: An interval is N when one gap is sampled at edge t and the next at edge t+N. An interval of 16 to 31 decodes as a 0 bit; an interval of 48 to 64 decodes as a 1 bit.
- R5: An interval below 16, or from 32 to 47, is an error. The error is sticky for the rest of the command and ends it with rd_restart instead of prog_req.
- R6: When no gap follows the last gap at edge t through edge t+64, write_mode drops after edge t+64. Exactly one of prog_req or rd_restart is 1 for that one clock only.
- R7: A command of exactly 38 bits, with bit 1 = 1, bit 2 = 0 and no error, gives prog_req. Fields are counted in the order the bits are received. cmd_lock takes bit 3. cmd_data[31] down to cmd_data[0] take bits 4 to 35. cmd_addr[2] down to cmd_addr[0] take bits 36 to 38. All three outputs are valid in the same clock as prog_req.
- R8: If the first two bits are anything other than 1 then 0, the command gives rd_restart.
- R9: A bit count other than 38 gives rd_restart. This includes 0, fewer than 38 and any number above 38; the counter stops at 39.
- R10: After either result, the block returns to idle. The next start gap begins a fresh command with the error and bit count cleared.
- R11: cmd_lock, cmd_data and cmd_addr change only together with prog_req. They hold their values through failed and aborted commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| gap_pulse | input | 1 | Synchronised gap detect, one clock per gap |
| cfg_loaded | input | 1 | Configuration block has been loaded |
| otp_disable | input | 1 | Mode bit that disables writing |
| write_mode | output | 1 | A command is being received |
| damp_en | output | 1 | Keep the coil load switched on |
| cmd_lock | output | 1 | Latched lock bit of the last good command |
| cmd_data | output | 32 | Latched data word, first data bit in the MSB |
| cmd_addr | output | 3 | Latched block address, first address bit in the MSB |
| prog_req | output | 1 | One-clock programming request |
| rd_restart | output | 1 | One-clock request to restart reading at block 1, bit 1 |

## Verification
The decoder holds all of its evidence until the quiet timeout, so most internal faults show up at the ports 65 clocks after the last gap. A wrong interval class, a lost sticky error or a shifted bit count turns into a pulse of the wrong kind, or into a misplaced bit in cmd_data or cmd_addr. A counter that restarts on the wrong edge moves the end of write_mode earlier or later by a clock. Intervals at the exact window limits and commands of 37, 39 and 45 bits separate these faults from a correct design.

// File: rtl/gapdec_pkg.sv
package gapdec_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_REPORT = 2'd3
    } wr_state_t;

    typedef enum logic [1:0] {
        IV_BAD  = 2'd0,
        IV_ZERO = 2'd1,
        IV_ONE  = 2'd2
    } iv_class_t;

    localparam int OP_W = 2;
    localparam logic [OP_W-1:0] WRITE_OPCODE = 2'b10;
endpackage

// File: rtl/gapdec_interval_timer.sv
module gapdec_interval_timer
    import gapdec_pkg::*;
#(
    parameter int ZERO_MIN    = 16,
    parameter int ZERO_END    = 32,
    parameter int ONE_MIN     = 48,
    parameter int QUIET_LIMIT = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gap,
    output iv_class_t iv_class,
    output logic      expired
);
    localparam int CNT_W = $clog2(QUIET_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(QUIET_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Clocks since the last gap edge; the gap cycle counts as 1 on the next clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= SAT_VAL;
        end else if (gap) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != SAT_VAL) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        if (cnt_q < CNT_W'(ZERO_MIN)) begin
            iv_class = IV_BAD;
        end else if (cnt_q < CNT_W'(ZERO_END)) begin
            iv_class = IV_ZERO;
        end else if (cnt_q < CNT_W'(ONE_MIN)) begin
            iv_class = IV_BAD;
        end else if (cnt_q <= CNT_W'(QUIET_LIMIT)) begin
            iv_class = IV_ONE;
        end else begin
            iv_class = IV_BAD;
        end
    end

    assign expired = (cnt_q == CNT_W'(QUIET_LIMIT));

    // R6: expiry is seen for a single clock unless a gap restarts the count
    a_r6_expiry_single: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !gap) |=> !expired);
endmodule

// File: rtl/gapdec_cmd_shifter.sv
module gapdec_cmd_shifter #(
    parameter int CMD_W = 38,
    parameter int BC_W  = $clog2(CMD_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CMD_W-1:0] cmd_q,
    output logic [BC_W-1:0]  bit_cnt
);
    localparam logic [BC_W-1:0] CNT_SAT = BC_W'(CMD_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (clear) begin
            cmd_q <= '0;
        end else if (shift_en) begin
            cmd_q <= {cmd_q[CMD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (shift_en && bit_cnt != CNT_SAT) begin
            bit_cnt <= bit_cnt + BC_W'(1);
        end
    end

    // R9: once saturated the count stays put until a new command clears it
    a_r9_count_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_SAT && !clear) |=> bit_cnt == CNT_SAT);
endmodule

// File: rtl/gapdec_verdict.sv
module gapdec_verdict
    import gapdec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CMD_W  = OP_W + 1 + DATA_W + ADDR_W,
    parameter int BC_W   = $clog2(CMD_W + 2)
) (
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [BC_W-1:0]   bit_cnt,
    input  logic              err_seen,
    output logic              ok,
    output logic              f_lock,
    output logic [DATA_W-1:0] f_data,
    output logic [ADDR_W-1:0] f_addr
);
    logic [OP_W-1:0] f_op;

    // First received bit sits at the MSB of the command register.
    assign f_op   = cmd_q[CMD_W-1 -: OP_W];
    assign f_lock = cmd_q[DATA_W + ADDR_W];
    assign f_data = cmd_q[ADDR_W +: DATA_W];
    assign f_addr = cmd_q[ADDR_W-1:0];

    assign ok = !err_seen && (bit_cnt == BC_W'(CMD_W)) && (f_op == WRITE_OPCODE);
endmodule

// File: rtl/rf_gap_write_decoder.sv
module rf_gap_write_decoder
    import gapdec_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int ZERO_MIN    = 16,
    parameter int ZERO_END    = 32,
    parameter int ONE_MIN     = 48,
    parameter int QUIET_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gap_pulse,
    input  logic              cfg_loaded,
    input  logic              otp_disable,
    output logic              write_mode,
    output logic              damp_en,
    output logic              cmd_lock,
    output logic [DATA_W-1:0] cmd_data,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              prog_req,
    output logic              rd_restart
);
    localparam int CMD_W = OP_W + 1 + DATA_W + ADDR_W;
    localparam int BC_W  = $clog2(CMD_W + 2);

    wr_state_t         state_q, state_d;
    iv_class_t         iv_class;
    logic              expired;
    logic              armed, start_gap, data_gap, finish;
    logic              err_seen_q, verdict_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [BC_W-1:0]   bit_cnt;
    logic              v_ok, v_lock;
    logic [DATA_W-1:0] v_data;
    logic [ADDR_W-1:0] v_addr;

    assign armed     = cfg_loaded && !otp_disable;
    assign start_gap = (state_q == ST_IDLE) && armed && gap_pulse;
    assign data_gap  = (state_q == ST_WRITE) && armed && gap_pulse;
    assign finish    = (state_q == ST_WRITE) && armed && !gap_pulse && expired;

    gapdec_interval_timer #(
        .ZERO_MIN   (ZERO_MIN),
        .ZERO_END   (ZERO_END),
        .ONE_MIN    (ONE_MIN),
        .QUIET_LIMIT(QUIET_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .gap     (gap_pulse),
        .iv_class(iv_class),
        .expired (expired)
    );

    gapdec_cmd_shifter #(
        .CMD_W(CMD_W),
        .BC_W (BC_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_gap),
        .shift_en(data_gap && iv_class != IV_BAD),
        .bit_in  (iv_class == IV_ONE),
        .cmd_q   (cmd_q),
        .bit_cnt (bit_cnt)
    );

    gapdec_verdict #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CMD_W (CMD_W),
        .BC_W  (BC_W)
    ) u_verdict (
        .cmd_q   (cmd_q),
        .bit_cnt (bit_cnt),
        .err_seen(err_seen_q),
        .ok      (v_ok),
        .f_lock  (v_lock),
        .f_data  (v_data),
        .f_addr  (v_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, start, bit, quiet, done, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (armed) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!armed)         state_d = ST_OFF;
                else if (gap_pulse) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (!armed)      state_d = ST_OFF;
                else if (finish) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Sticky error, verdict and latched command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_seen_q <= 1'b0;
            verdict_q  <= 1'b0;
            cmd_lock   <= 1'b0;
            cmd_data   <= '0;
            cmd_addr   <= '0;
        end else begin
            if (start_gap) begin
                err_seen_q <= 1'b0;
            end else if (data_gap && iv_class == IV_BAD) begin
                err_seen_q <= 1'b1;
            end
            if (finish) begin
                verdict_q <= v_ok;
                if (v_ok) begin
                    cmd_lock <= v_lock;
                    cmd_data <= v_data;
                    cmd_addr <= v_addr;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        write_mode = 1'b0;
        prog_req   = 1'b0;
        rd_restart = 1'b0;
        unique case (state_q)
            ST_WRITE:  write_mode = 1'b1;
            ST_REPORT: begin
                prog_req   = verdict_q;
                rd_restart = !verdict_q;
            end
            default: ;
        endcase
        damp_en = write_mode;
    end

    // R3: write mode only begins right after a sampled gap
    a_r3_start_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_mode) |-> $past(gap_pulse));

    // R2: loss of the arm condition leaves write mode on the next clock
    a_r2_disarm_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_loaded || otp_disable) |=> !write_mode);

    // R6: result pulses are one clock wide and only follow write mode
    a_r6_prog_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    a_r6_restart_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        rd_restart |=> !rd_restart);
    a_r6_result_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || rd_restart) |-> $past(write_mode));

    // R11: latched fields move only together with a programming request
    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_req |-> ($stable(cmd_data) && $stable(cmd_addr) && $stable(cmd_lock)));
endmodule

// File: tb/rf_gap_write_decoder_bench.sv
module rf_gap_write_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n, gap_pulse, cfg_loaded, otp_disable;
    logic        write_mode, damp_en, cmd_lock, prog_req, rd_restart;
    logic [31:0] cmd_data;
    logic [2:0]  cmd_addr;

    int checks = 0;
    int fails  = 0;
    int n_prog = 0;
    int n_rst  = 0;
    bit done   = 1'b0;

    logic [63:0] bits;
    logic        exp_lock = 1'b0;
    logic [31:0] exp_data = '0;
    logic [2:0]  exp_addr = '0;

    always #2 clk = ~clk;

    rf_gap_write_decoder u_rf_gap_write_decoder (
        .clk(clk), .rst_n(rst_n), .gap_pulse(gap_pulse), .cfg_loaded(cfg_loaded),
        .otp_disable(otp_disable), .write_mode(write_mode), .damp_en(damp_en),
        .cmd_lock(cmd_lock), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
        .prog_req(prog_req), .rd_restart(rd_restart)
    );

    always @(negedge clk) begin
        if (prog_req)   n_prog++;
        if (rd_restart) n_rst++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Gap raised at this negedge, sampled at one rising edge, dropped next negedge.
    task automatic pulse_gap();
        gap_pulse = 1'b1;
        @(negedge clk);
        gap_pulse = 1'b0;
    endtask

    function automatic int pick_iv(input logic b, input int mode, input bit bad);
        int lst[4] = '{3, 15, 32, 47};
        if (bad) return lst[$urandom_range(0, 3)];
        if (b) return (mode == 1) ? 48 : (mode == 2) ? 64 : int'($urandom_range(48, 64));
        return (mode == 1) ? 16 : (mode == 2) ? 31 : int'($urandom_range(16, 31));
    endfunction

    task automatic make_bits(input logic [1:0] op);
        bits = {$urandom, $urandom};
        bits[0] = op[1];
        bits[1] = op[0];
    endtask

    // Start gap, n bit gaps, quiet period, then check the result clock.
    task automatic run_cmd(input int n, input int bad_at, input int mode, input string tag);
        bit eok;
        int p0, r0;
        eok = (bad_at < 0) && (n == 38) && bits[0] && !bits[1];
        pulse_gap();
        chk("R3 write_mode after start", 64'(write_mode), 64'd1);
        chk("R3 damp_en after start", 64'(damp_en), 64'd1);
        for (int i = 0; i < n; i++) begin
            int iv;
            iv = pick_iv(bits[i], mode, i == bad_at);
            repeat (iv - 1) @(negedge clk);
            pulse_gap();
        end
        repeat (63) @(negedge clk);
        chk("R6 still writing at limit", 64'(write_mode), 64'd1);
        p0 = n_prog;
        r0 = n_rst;
        @(negedge clk);
        if (eok) begin
            exp_lock = bits[2];
            for (int j = 0; j < 32; j++) exp_data[31-j] = bits[3+j];
            for (int j = 0; j < 3; j++)  exp_addr[2-j]  = bits[35+j];
        end
        chk({tag, " prog_req"}, 64'(prog_req), 64'(eok));
        chk({tag, " rd_restart"}, 64'(rd_restart), 64'(!eok));
        chk("R6 write_mode dropped", 64'(write_mode), 64'd0);
        chk("R7/R11 lock", 64'(cmd_lock), 64'(exp_lock));
        chk("R4/R7/R11 data", 64'(cmd_data), 64'(exp_data));
        chk("R7/R11 addr", 64'(cmd_addr), 64'(exp_addr));
        @(negedge clk);
        chk("R6 single pulse", 64'((n_prog - p0) + (n_rst - r0)), 64'd1);
        chk("R6 pulses low", 64'(prog_req | rd_restart), 64'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1d5e_5eed));
        rst_n = 1'b0; gap_pulse = 1'b0; cfg_loaded = 1'b0; otp_disable = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 write_mode", 64'(write_mode), 64'd0);
        chk("R1 damp_en", 64'(damp_en), 64'd0);
        chk("R1 pulses", 64'(prog_req | rd_restart), 64'd0);
        chk("R1 fields", {cmd_lock, cmd_data, cmd_addr}, 64'd0);

        // R2: not configured, then OTP-disabled
        for (int k = 0; k < 2; k++) begin
            cfg_loaded  = (k == 1);
            otp_disable = (k == 1);
            @(negedge clk);
            for (int g = 0; g < 4; g++) begin
                pulse_gap();
                chk("R2 ignored gap", 64'(write_mode), 64'd0);
                repeat (23) @(negedge clk);
            end
        end
        repeat (70) @(negedge clk);
        chk("R2 no pulse while disarmed", 64'(n_prog + n_rst), 64'd0);
        otp_disable = 1'b0;
        cfg_loaded  = 1'b1;
        repeat (2) @(negedge clk);

        // R4/R7: window limits, then random legal spacing
        make_bits(2'b10); run_cmd(38, -1, 1, "R7 low bounds");
        make_bits(2'b10); run_cmd(38, -1, 2, "R7 high bounds");
        for (int r = 0; r < 6; r++) begin
            make_bits(2'b10); run_cmd(38, -1, 0, "R7 random");
        end
        // R5 bad intervals at several positions
        make_bits(2'b10); run_cmd(38, 10, 0, "R5 bad interval");
        make_bits(2'b10); run_cmd(38, 0, 0, "R5 bad first");
        make_bits(2'b10); run_cmd(38, 37, 0, "R5 bad last");
        // R8 opcodes
        make_bits(2'b11); run_cmd(38, -1, 0, "R8 op 11");
        make_bits(2'b00); run_cmd(38, -1, 0, "R8 op 00");
        make_bits(2'b01); run_cmd(38, -1, 0, "R8 op 01");
        // R9 counts
        make_bits(2'b10); run_cmd(37, -1, 0, "R9 37 bits");
        make_bits(2'b10); run_cmd(39, -1, 0, "R9 39 bits");
        make_bits(2'b10); run_cmd(45, -1, 0, "R9 45 bits");
        make_bits(2'b10); run_cmd(0, -1, 0, "R9 no bits");
        // R10 fresh command after a failure
        make_bits(2'b10); run_cmd(38, 5, 0, "R5 before recovery");
        make_bits(2'b10); run_cmd(38, -1, 0, "R10 recovery");

        // R2 disarm in the middle of a command
        begin
            int p0, r0;
            p0 = n_prog; r0 = n_rst;
            pulse_gap();
            for (int g = 0; g < 3; g++) begin
                repeat (23) @(negedge clk);
                pulse_gap();
            end
            cfg_loaded = 1'b0;
            @(negedge clk);
            chk("R2 disarm drops write_mode", 64'(write_mode), 64'd0);
            repeat (80) @(negedge clk);
            chk("R2 no pulse after disarm", 64'((n_prog - p0) + (n_rst - r0)), 64'd0);
            chk("R11 fields held on abort", {cmd_lock, cmd_data, cmd_addr},
                {28'd0, exp_lock, exp_data, exp_addr});
            cfg_loaded = 1'b1;
            repeat (2) @(negedge clk);
        end
        make_bits(2'b10); run_cmd(38, -1, 0, "R10 after abort");

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule